// File: doc/BRIEF.md
# Priority Round-Robin Flow Scheduler

This block decides which flow a queue manager should dequeue next. Every flow has a non-empty indication and a 2-bit priority level held inside the block. The block always serves the highest level that has at least one non-empty flow. Inside that level it rotates among the non-empty flows. Each of the four levels keeps its own rotation pointer.

A decision is presented as a registered grant: a flow index, the level it was chosen from, and a valid strobe. The grant stays in place until the dequeue logic acknowledges it. An acknowledge also moves that level's pointer to just past the served flow.

Giving every flow the same level makes the block a plain round-robin. Giving every flow its own level makes it strict priority. A registered all-empty output reports that no level has any work.

Top module: `prio_rr_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `grant_valid` is low and `all_empty` is high. After reset, every flow's level is 0 and every level's pointer is 0.
- R2: Level 3 is the most urgent and level 0 the least. When a grant is formed, it comes from the highest level that has a non-empty flow.
- R3: Within the chosen level, the search starts at that level's pointer and moves to increasing indices, wrapping from N_FLOWS-1 to 0. The flow at the pointer position is checked first.
- R4: A level's pointer changes only on a cycle where `grant_valid` and `grant_ack` are both high and the grant came from that level. It then becomes (grant_idx+1) mod N_FLOWS. All other pointers keep their values.
- R5: `grant_valid` rises on the clock edge after a cycle with no grant pending and at least one non-empty flow. While `grant_ack` is low, `grant_valid`, `grant_idx` and `grant_lvl` hold steady. `grant_valid` falls on the edge that samples `grant_ack` high.
- R6: `all_empty` is registered. It is high one cycle after a cycle in which every level had no non-empty flow, and low one cycle after any flow was non-empty.
- R7: A level write (`cfg_we`, `cfg_idx`, `cfg_lvl`) takes effect only if that flow's `flow_busy` bit is low at the same edge. Otherwise the write is ignored.
- R8: `grant_lvl` equals the level the granted flow had when the grant was formed.
- R9: With all flows at one level, grants follow plain round-robin order. With every busy flow at its own level, the most urgent busy flow is always chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_busy | input | N_FLOWS | Per-flow non-empty indication, bit i for flow i |
| cfg_we | input | 1 | Level write strobe |
| cfg_idx | input | IDX_W | Flow whose level is written |
| cfg_lvl | input | 2 | New level, 3 most urgent |
| grant_ack | input | 1 | Dequeue logic accepts the current grant |
| grant_valid | output | 1 | A grant is pending |
| grant_idx | output | IDX_W | Granted flow index |
| grant_lvl | output | 2 | Level the grant was chosen from |
| all_empty | output | 1 | No flow is non-empty in any level |

## Verification
The bench builds the block with its default of 16 flows. At that size, wrap-around from index 15 back to 0 occurs within a few grants, and four levels can each hold several flows at once. The bench runs these scenarios:
- The same busy set under uniform levels, where the block must act as plain round-robin.
- Fully distinct levels, where it must act as strict priority.
- A mix in which one level's pointer must survive while another level is being served.
- A level write aimed at a busy flow, which must be ignored, checked by watching `grant_lvl`.

// File: rtl/prio_rr_pkg.sv
package prio_rr_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = 2;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/prio_rr_table.sv
// Per-flow level storage; a write lands only when the flow is empty.
module prio_rr_table
  import prio_rr_pkg::*;
#(
  parameter int unsigned N_FLOWS = 16,
  localparam int unsigned IDX_W = $clog2(N_FLOWS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_FLOWS-1:0]       flow_busy,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  lvl_t                     cfg_lvl,
  output logic [N_FLOWS*LVL_W-1:0] prio_flat
);
  for (genvar i = 0; i < N_FLOWS; i++) begin : g_flow
    lvl_t lvl_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q <= '0;
      end else if (cfg_we && (cfg_idx == IDX_W'(i)) && !flow_busy[i]) begin
        lvl_q <= cfg_lvl;
      end
    end
    assign prio_flat[i*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/prio_rr_lvl_mask.sv
// Splits the busy vector into one eligibility mask per level.
module prio_rr_lvl_mask
  import prio_rr_pkg::*;
#(
  parameter int unsigned N_FLOWS = 16
) (
  input  logic [N_FLOWS-1:0]         flow_busy,
  input  logic [N_FLOWS*LVL_W-1:0]   prio_flat,
  output logic [NUM_LVL*N_FLOWS-1:0] elig_flat,
  output logic [NUM_LVL-1:0]         lvl_empty
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < N_FLOWS; i++) begin : g_flow
      assign elig_flat[l*N_FLOWS + i] =
        flow_busy[i] && (prio_flat[i*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign lvl_empty[l] = ~|elig_flat[l*N_FLOWS +: N_FLOWS];
  end
endmodule

// File: rtl/prio_rr_pick.sv
// Rotating first-set search starting at the pointer position.
module prio_rr_pick #(
  parameter int unsigned N_FLOWS = 16,
  localparam int unsigned IDX_W = $clog2(N_FLOWS)
) (
  input  logic [N_FLOWS-1:0] mask,
  input  logic [IDX_W-1:0]   ptr,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    int pos;
    found = 1'b0;
    idx   = '0;
    pos   = 0;
    // Walk from farthest to nearest so the nearest hit wins.
    for (int k = N_FLOWS - 1; k >= 0; k--) begin
      pos = int'(ptr) + k;
      if (pos >= int'(N_FLOWS)) pos = pos - int'(N_FLOWS);
      if (mask[pos]) begin
        found = 1'b1;
        idx   = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/prio_rr_sched.sv
module prio_rr_sched
  import prio_rr_pkg::*;
#(
  parameter int unsigned N_FLOWS = 16,
  localparam int unsigned IDX_W = $clog2(N_FLOWS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FLOWS-1:0] flow_busy,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [1:0]         cfg_lvl,
  input  logic               grant_ack,
  output logic               grant_valid,
  output logic [IDX_W-1:0]   grant_idx,
  output logic [1:0]         grant_lvl,
  output logic               all_empty
);
  logic [N_FLOWS*LVL_W-1:0]   prio_flat;
  logic [NUM_LVL*N_FLOWS-1:0] elig_flat;
  logic [NUM_LVL-1:0]         lvl_empty;
  logic [NUM_LVL*IDX_W-1:0]   ptr_flat;
  logic [NUM_LVL*IDX_W-1:0]   pick_flat;
  logic [NUM_LVL-1:0]         pick_found;
  logic                       sel_found;
  logic [IDX_W-1:0]           sel_idx;
  lvl_t                       sel_lvl;
  logic                       take;

  assign take = grant_valid && grant_ack;

  prio_rr_table #(.N_FLOWS(N_FLOWS)) table_i (
    .clk(clk), .rst(rst), .flow_busy(flow_busy),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
    .prio_flat(prio_flat)
  );

  prio_rr_lvl_mask #(.N_FLOWS(N_FLOWS)) mask_i (
    .flow_busy(flow_busy), .prio_flat(prio_flat),
    .elig_flat(elig_flat), .lvl_empty(lvl_empty)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [IDX_W-1:0] ptr_q;

    prio_rr_pick #(.N_FLOWS(N_FLOWS)) pick_i (
      .mask(elig_flat[l*N_FLOWS +: N_FLOWS]),
      .ptr(ptr_q),
      .found(pick_found[l]),
      .idx(pick_flat[l*IDX_W +: IDX_W])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q <= '0;
      end else if (take && (grant_lvl == LVL_W'(l))) begin
        if (grant_idx == IDX_W'(N_FLOWS - 1)) ptr_q <= '0;
        else                                  ptr_q <= grant_idx + 1'b1;
      end
    end
    assign ptr_flat[l*IDX_W +: IDX_W] = ptr_q;
  end

  // Highest non-empty level wins; ascending loop lets later levels override.
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    sel_lvl   = '0;
    for (int l = 0; l < int'(NUM_LVL); l++) begin
      if (pick_found[l]) begin
        sel_found = 1'b1;
        sel_idx   = pick_flat[l*IDX_W +: IDX_W];
        sel_lvl   = LVL_W'(l);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
      grant_lvl   <= '0;
      all_empty   <= 1'b1;
    end else begin
      all_empty <= &lvl_empty;
      if (take) begin
        grant_valid <= 1'b0;
      end else if (!grant_valid && sel_found) begin
        grant_valid <= 1'b1;
        grant_idx   <= sel_idx;
        grant_lvl   <= sel_lvl;
      end
    end
  end
endmodule

// File: rtl/prio_rr_sched_chk.sv
module prio_rr_sched_chk #(
  parameter int unsigned N_FLOWS = 16,
  localparam int unsigned IDX_W = $clog2(N_FLOWS)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_FLOWS-1:0] flow_busy,
  input logic               grant_ack,
  input logic               grant_valid,
  input logic [IDX_W-1:0]   grant_idx,
  input logic [1:0]         grant_lvl,
  input logic               all_empty,
  input logic [N_FLOWS*2-1:0] prio_flat,
  input logic [4*IDX_W-1:0] ptr_flat
);
  logic [N_FLOWS-1:0]   busy_d;
  logic [N_FLOWS*2-1:0] prio_d;
  always_ff @(posedge clk) begin
    busy_d <= flow_busy;
    prio_d <= prio_flat;
  end

  p_hold_grant_r5: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !grant_ack) |=> (grant_valid && $stable(grant_idx) && $stable(grant_lvl)));

  p_drop_on_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && grant_ack) |=> !grant_valid);

  p_empty_set_r6: assert property (@(posedge clk) disable iff (rst)
    (flow_busy == '0) |=> all_empty);

  p_empty_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (flow_busy != '0) |=> !all_empty);

  p_ptr_ack_only_r4: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && grant_ack) |=> $stable(ptr_flat));

  p_grant_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> busy_d[grant_idx]);

  p_grant_lvl_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> (prio_d[grant_idx*2 +: 2] == grant_lvl));
endmodule

bind prio_rr_sched prio_rr_sched_chk #(.N_FLOWS(N_FLOWS)) chk_i (
  .clk(clk), .rst(rst), .flow_busy(flow_busy), .grant_ack(grant_ack),
  .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_lvl(grant_lvl),
  .all_empty(all_empty), .prio_flat(prio_flat), .ptr_flat(ptr_flat)
);

// File: tb/prio_rr_sched_tb_top.sv
`timescale 1ns/1ps
module prio_rr_sched_tb_top;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  flow_busy = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [1:0]    cfg_lvl = '0;
  logic          grant_ack = 1'b0;
  logic          grant_valid;
  logic [IW-1:0] grant_idx;
  logic [1:0]    grant_lvl;
  logic          all_empty;

  always #2.5 clk = ~clk;

  prio_rr_sched #(.N_FLOWS(N)) dut_i (
    .clk(clk), .rst(rst), .flow_busy(flow_busy), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .grant_ack(grant_ack),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_lvl(grant_lvl),
    .all_empty(all_empty)
  );

  typedef struct { int idx; int lvl; string tag; } exp_t;
  exp_t exp_q[$];

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // Reference model state
  bit [N-1:0] busy_m = '0;
  int prio_m [N];
  int ptr_m [4];

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_pick(output int idx, output int lvl);
    idx = -1; lvl = -1;
    for (int l = 3; l >= 0; l--) begin
      for (int k = 0; k < N; k++) begin
        int p;
        p = (ptr_m[l] + k) % N;
        if (idx < 0 && busy_m[p] && prio_m[p] == l) begin
          idx = p; lvl = l;
        end
      end
    end
  endfunction

  task automatic set_busy(bit [N-1:0] v);
    flow_busy = v;
    busy_m = v;
  endtask

  task automatic set_prio(int idx, int lvl);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_lvl = 2'(lvl);
    if (!busy_m[idx]) prio_m[idx] = lvl;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: push the expected grant, wait for it, optionally hold, then ack.
  task automatic serve(string tag, int hold);
    int ei, el, waited;
    exp_t e;
    model_pick(ei, el);
    e.idx = ei; e.lvl = el; e.tag = tag;
    exp_q.push_back(e);
    waited = 0;
    while (!grant_valid && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    if (!grant_valid) begin
      check({tag, " R5 grant timeout"}, 0, 1);
      void'(exp_q.pop_front());
      return;
    end
    #2;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R5 valid held", int'(grant_valid), 1);
      check("R5 idx held", int'(grant_idx), ei);
    end
    grant_ack = 1'b1;
    @(negedge clk);
    grant_ack = 1'b0;
    check("R5 valid drops after ack", int'(grant_valid), 0);
    ptr_m[el] = (ei + 1) % N;
  endtask

  // Monitor: compare each new grant against the scoreboard head.
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      #1;
      if (!rst && grant_valid && !prev) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected grant", int'(grant_idx), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " idx"}, int'(grant_idx), e.idx);
          check("R8 grant_lvl", int'(grant_lvl), e.lvl);
        end
      end
      prev = grant_valid;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    for (int l = 0; l < 4; l++) ptr_m[l] = 0;

    repeat (4) @(negedge clk);
    check("R1 valid in reset", int'(grant_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(grant_valid), 0);
    check("R1 all_empty after reset", int'(all_empty), 1);

    // Uniform level: plain round-robin (R9, R3)
    set_busy(16'h8212);
    serve("R9 uniform rr", 0);
    check("R6 all_empty low when busy", int'(all_empty), 0);
    for (int i = 0; i < 5; i++) serve("R9 uniform rr", 0);

    // Wrap-around from high index back to low (R3)
    set_busy(16'h8004);
    for (int i = 0; i < 3; i++) serve("R3 wrap", 0);

    set_busy('0);
    @(negedge clk);
    check("R6 all_empty high when idle", int'(all_empty), 1);

    // Distinct levels: strict priority (R9, R2)
    set_prio(2, 3); set_prio(7, 2); set_prio(11, 1); set_prio(12, 0);
    set_busy(16'h1884);
    serve("R2 strict top", 0);
    serve("R2 strict top again", 0);
    set_busy(16'h1880);
    serve("R2 strict next", 0);
    set_busy(16'h1800);
    serve("R2 strict next", 0);
    set_busy(16'h1000);
    serve("R2 strict lowest", 0);
    set_busy('0);
    @(negedge clk);

    // Per-level pointers stay independent (R4)
    set_prio(3, 2); set_prio(6, 2); set_prio(0, 0); set_prio(8, 0);
    set_busy(16'h0149);
    for (int i = 0; i < 3; i++) serve("R4 level2 rotation", 0);
    set_busy(16'h0101);
    for (int i = 0; i < 3; i++) serve("R4 level0 pointer kept", 0);
    set_busy('0);
    @(negedge clk);

    // Level write to a busy flow is ignored (R7)
    set_prio(5, 1);
    set_busy(16'h0220);
    set_prio(5, 3);
    serve("R7 write ignored while busy", 0);
    set_busy('0);
    @(negedge clk);
    set_prio(5, 3);
    set_busy(16'h0220);
    serve("R7 write applied while empty", 0);

    // Grant held while ack is withheld (R5)
    serve("R5 hold", 4);
    set_busy('0);
    repeat (3) @(negedge clk);
    check("R5 no grant when idle", int'(grant_valid), 0);
    check("R6 all_empty final", int'(all_empty), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule